// File: doc/BRIEF.md
# Serial configuration word receiver

This block takes configuration words from a board controller over one serial data line. The line is timed by a slow word clock, and the block samples the line on each falling edge of that clock. A frame opens with a low start bit. Fifteen payload bits follow, most significant first. The frame then needs a run of sixteen high idle bits before its contents are committed. The three least significant payload bits name the destination register. The upper twelve bits are the field data for that register.

The committed registers drive the analog configuration pins:
- receive gain and input-attenuation select,
- receive filter forcing and external gain pins,
- transmit gain and the general-purpose outputs,
- oversampling mode, loopback mode and the enables,
- the two filter-tuning codes,
- the tuning-DAC value,
- per-block power-down enables.

A separate power-down input is synchronised into the system clock domain. While that input is active, the transmit gain output is forced to its maximum. The stored register contents are kept throughout.

The block runs on the system clock, and the word clock is treated as a data input. The system clock must be several times faster than the word clock. Every successful commit raises a one-cycle pulse.

Top module: `cfgrx_serial_cfg`

## Requirements
- R1: The data line is sampled only in the system-clock cycle in which a falling edge of the word clock is detected (word clock high at the previous clock edge, low now). Changes of the data line at any other time have no effect.
- R2: A frame is a 0 start bit followed by 15 payload bits, most significant first. Payload bits [2:0] are the register identifier, and bits [14:3] carry the field data.
- R3: A frame is committed on the 16th consecutive high sample after its last payload bit. The new register values and the commit pulse appear after the clock edge that takes that sample. After only 15 high samples, nothing has changed.
- R4: A low sample while idle bits are being counted discards the pending frame. That low sample is taken as the start bit of a new frame.
- R5: Identifiers 5, 6 and 7 are reserved. A frame carrying one changes no output and gives no commit pulse.
- R6: After reset, every field is 0, except that the input select is 2'b11. This gives minimum gains, oversampling ratio 4, nominal filter codes, the tuning DAC disabled and no loopback.
- R7: Identifier 0 loads four fields:
  - receive gain (code = dB, 0..31) from bits [7:3],
  - input select from [9:8],
  - filter force mode from [11:10],
  - external gain pins from [13:12].
- R8: Identifier 1 loads two fields:
  - transmit gain code from bits [6:3] (code c means c-15 dB, so 0 is -15 dB and 15 is 0 dB),
  - general-purpose outputs from [9:7].
- R9: Identifier 2 loads the mode fields:
  - oversampling flag (1 means ratio 2) from bit [3],
  - loopback mode from [5:4],
  - tuning DAC enable from [6],
  - second filter enable from [7],
  - filtered oscillator control from [8],
  - transmit-filter tuning code from [11:9] and receive-filter tuning code from [14:12], each two's complement from -4 to +3.
- R10: Identifier 3 loads the 8-bit tuning-DAC value from bits [10:3]. Identifier 4 loads the 8 power-down enables from bits [10:3].
- R11: The power-down status output follows the power-down input two clock edges later. While the status is high, the transmit gain output reads 15, and register writes are still taken. When the status falls, the stored transmit gain reappears.
- R12: The commit pulse is high for exactly one clock cycle per committed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk | input | 1 | Word clock, synchronous to clk, sampled as data |
| sdin | input | 1 | Serial configuration data |
| pd_in | input | 1 | Power-down request |
| rx_gain | output | 5 | Receive gain code, dB |
| rx_in_sel | output | 2 | Receive input / attenuation select |
| rx_filt_mode | output | 2 | Receive filter force mode |
| ext_gc | output | 2 | External gain control pins |
| tx_gain | output | 4 | Effective transmit gain code |
| gpo | output | 3 | General-purpose outputs |
| osr2 | output | 1 | 1 = oversampling ratio 2, 0 = ratio 4 |
| loopback | output | 2 | Loopback mode |
| vcodac_en | output | 1 | Tuning DAC enable |
| hc2_en | output | 1 | Second receive filter enable |
| vcxo_filt | output | 1 | Filtered oscillator control |
| sc_tune | output | 3 | Transmit filter tuning code |
| hc_tune | output | 3 | Receive filter tuning code |
| vcodac_val | output | 8 | Tuning DAC value |
| blk_pd | output | 8 | Per-block power-down enables |
| pd_active | output | 1 | Synchronised power-down status |
| commit | output | 1 | One-cycle pulse per committed frame |

## Verification
The assertions check a set of rules on every cycle:
- the frame state never moves without a word-clock falling edge,
- a completed frame returns the receiver to idle,
- a low idle sample restarts the frame,
- a reserved identifier leaves the registers untouched,
- the commit pulse lasts a single cycle,
- transmit gain is forced while powered down.

Field placement is shown only by the bench's scenarios, which compare every output against a behavioural model on every clock:
- the exact commit moment after the sixteenth idle bit,
- the discarding of a frame cut short,
- immunity to line glitches between word-clock edges,
- the return of the stored gain after power-down.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
  localparam int WORD_W = 16;
  localparam int PAY_W  = WORD_W - 1;
  localparam int ID_W   = 3;

  typedef struct packed {
    logic [4:0] rx_gain;
    logic [1:0] rx_in_sel;
    logic [1:0] rx_filt_mode;
    logic [1:0] ext_gc;
    logic [3:0] tx_gain;
    logic [2:0] gpo;
    logic       osr2;
    logic [1:0] loopback;
    logic       vcodac_en;
    logic       hc2_en;
    logic       vcxo_filt;
    logic [2:0] sc_tune;
    logic [2:0] hc_tune;
    logic [7:0] vcodac_val;
    logic [7:0] blk_pd;
  } cfg_t;

  // R6: defaults applied on reset
  function automatic cfg_t cfg_reset();
    cfg_t c;
    c = '0;
    c.rx_in_sel = 2'b11;
    return c;
  endfunction

  // R5: identifiers 5..7 are reserved
  function automatic logic id_reserved(logic [ID_W-1:0] id);
    return id >= ID_W'(5);
  endfunction

  // R7..R10: merge one payload word into the register image
  function automatic cfg_t cfg_apply(cfg_t c, logic [PAY_W-1:0] w);
    cfg_t n;
    n = c;
    case (w[ID_W-1:0])
      3'd0: begin
        n.rx_gain      = w[7:3];
        n.rx_in_sel    = w[9:8];
        n.rx_filt_mode = w[11:10];
        n.ext_gc       = w[13:12];
      end
      3'd1: begin
        n.tx_gain = w[6:3];
        n.gpo     = w[9:7];
      end
      3'd2: begin
        n.osr2      = w[3];
        n.loopback  = w[5:4];
        n.vcodac_en = w[6];
        n.hc2_en    = w[7];
        n.vcxo_filt = w[8];
        n.sc_tune   = w[11:9];
        n.hc_tune   = w[14:12];
      end
      3'd3: n.vcodac_val = w[10:3];
      3'd4: n.blk_pd     = w[10:3];
      default: n = c;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/cfgrx_frame.sv
module cfgrx_frame #(
  parameter int WORD_W    = 16,
  parameter int STOP_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wclk,
  input  logic              sdin,
  output logic              word_done_o,
  output logic [WORD_W-2:0] word_o
);
  localparam int PAY_W  = WORD_W - 1;
  localparam int BIT_W  = $clog2(PAY_W + 1);
  localparam int STOP_W = $clog2(STOP_BITS + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_STOP} phase_t;

  phase_t             phase;
  logic               wclk_q;
  logic               fall;
  logic               last_data;
  logic [BIT_W-1:0]   bit_cnt;
  logic [STOP_W-1:0]  stop_cnt;
  logic [PAY_W-1:0]   shreg;

  assign fall        = wclk_q & ~wclk;
  assign last_data   = (bit_cnt == BIT_W'(PAY_W - 1));
  assign word_done_o = fall && (phase == PH_STOP) && sdin &&
                       (stop_cnt == STOP_W'(STOP_BITS - 1));
  assign word_o      = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q   <= 1'b0;
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      stop_cnt <= '0;
      shreg    <= '0;
    end else begin
      wclk_q <= wclk;
      if (fall) begin
        case (phase)
          PH_IDLE: begin
            if (!sdin) begin
              phase   <= PH_DATA;
              bit_cnt <= '0;
            end
          end
          PH_DATA: begin
            shreg   <= {shreg[PAY_W-2:0], sdin};
            bit_cnt <= bit_cnt + 1'b1;
            if (last_data) begin
              phase    <= PH_STOP;
              stop_cnt <= '0;
            end
          end
          PH_STOP: begin
            if (!sdin) begin
              phase   <= PH_DATA;
              bit_cnt <= '0;
            end else if (word_done_o) begin
              phase <= PH_IDLE;
            end else begin
              stop_cnt <= stop_cnt + 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  p_sample_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(phase) && $stable(shreg) && $stable(bit_cnt) && $stable(stop_cnt));

  p_done_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_done_o |=> phase == PH_IDLE);

  p_low_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && phase == PH_STOP && !sdin) |=> (phase == PH_DATA) && (bit_cnt == '0));
endmodule

// File: rtl/cfgrx_regs.sv
module cfgrx_regs
  import cfgrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PAY_W-1:0] wr_word,
  output cfg_t             cfg_o,
  output logic             commit_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o    <= cfg_reset();
      commit_o <= 1'b0;
    end else begin
      commit_o <= wr_en && !id_reserved(wr_word[ID_W-1:0]);
      if (wr_en) cfg_o <= cfg_apply(cfg_o, wr_word);
    end
  end

  p_reserved_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && id_reserved(wr_word[ID_W-1:0])) |=> $stable(cfg_o) && !commit_o);

  p_commit_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
endmodule

// File: rtl/cfgrx_pd_sync.sv
module cfgrx_pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_in,
  output logic pd_o
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], pd_in};
  end

  assign pd_o = sh[STAGES-1];
endmodule

// File: rtl/cfgrx_serial_cfg.sv
module cfgrx_serial_cfg
  import cfgrx_pkg::*;
#(
  parameter int STOP_BITS = 16,
  parameter int PD_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wclk,
  input  logic       sdin,
  input  logic       pd_in,
  output logic [4:0] rx_gain,
  output logic [1:0] rx_in_sel,
  output logic [1:0] rx_filt_mode,
  output logic [1:0] ext_gc,
  output logic [3:0] tx_gain,
  output logic [2:0] gpo,
  output logic       osr2,
  output logic [1:0] loopback,
  output logic       vcodac_en,
  output logic       hc2_en,
  output logic       vcxo_filt,
  output logic [2:0] sc_tune,
  output logic [2:0] hc_tune,
  output logic [7:0] vcodac_val,
  output logic [7:0] blk_pd,
  output logic       pd_active,
  output logic       commit
);
  logic             word_done;
  logic [PAY_W-1:0] word;
  cfg_t             cfg;

  cfgrx_frame #(.WORD_W(WORD_W), .STOP_BITS(STOP_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .wclk(wclk), .sdin(sdin),
    .word_done_o(word_done), .word_o(word)
  );

  cfgrx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(word_done), .wr_word(word),
    .cfg_o(cfg), .commit_o(commit)
  );

  cfgrx_pd_sync #(.STAGES(PD_STAGES)) u_pd (
    .clk(clk), .rst_n(rst_n), .pd_in(pd_in), .pd_o(pd_active)
  );

  assign rx_gain      = cfg.rx_gain;
  assign rx_in_sel    = cfg.rx_in_sel;
  assign rx_filt_mode = cfg.rx_filt_mode;
  assign ext_gc       = cfg.ext_gc;
  assign tx_gain      = pd_active ? 4'hF : cfg.tx_gain;
  assign gpo          = cfg.gpo;
  assign osr2         = cfg.osr2;
  assign loopback     = cfg.loopback;
  assign vcodac_en    = cfg.vcodac_en;
  assign hc2_en       = cfg.hc2_en;
  assign vcxo_filt    = cfg.vcxo_filt;
  assign sc_tune      = cfg.sc_tune;
  assign hc_tune      = cfg.hc_tune;
  assign vcodac_val   = cfg.vcodac_val;
  assign blk_pd       = cfg.blk_pd;

  p_pd_tx_forced_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> tx_gain == 4'hF);
endmodule

// File: tb/cfgrx_serial_cfg_tb.sv
`timescale 1ns/1ps
module cfgrx_serial_cfg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wclk = 1'b0;
  logic sdin = 1'b1;
  logic pd_in = 1'b0;
  logic [4:0] rx_gain;
  logic [1:0] rx_in_sel, rx_filt_mode, ext_gc, loopback;
  logic [3:0] tx_gain;
  logic [2:0] gpo, sc_tune, hc_tune;
  logic osr2, vcodac_en, hc2_en, vcxo_filt, pd_active, commit;
  logic [7:0] vcodac_val, blk_pd;

  always #2 clk = ~clk;

  cfgrx_serial_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .wclk(wclk), .sdin(sdin), .pd_in(pd_in),
    .rx_gain(rx_gain), .rx_in_sel(rx_in_sel), .rx_filt_mode(rx_filt_mode),
    .ext_gc(ext_gc), .tx_gain(tx_gain), .gpo(gpo), .osr2(osr2),
    .loopback(loopback), .vcodac_en(vcodac_en), .hc2_en(hc2_en),
    .vcxo_filt(vcxo_filt), .sc_tune(sc_tune), .hc_tune(hc_tune),
    .vcodac_val(vcodac_val), .blk_pd(blk_pd), .pd_active(pd_active),
    .commit(commit)
  );

  int checks = 0;
  int fails  = 0;
  int ncommit = 0;
  bit started = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Behavioural reference model
  int m_rxg, m_sel, m_fm, m_gc, m_tx, m_gpo, m_osr, m_lb, m_ven, m_hc2, m_vf;
  int m_sc, m_hc, m_vco, m_bpd;
  int m_phase, m_stops;
  bit m_q[$];
  bit pdq[$];
  bit m_prev_w, e_commit, e_pd;

  task automatic model_reset();
    m_rxg = 0; m_sel = 3; m_fm = 0; m_gc = 0; m_tx = 0; m_gpo = 0;
    m_osr = 0; m_lb = 0; m_ven = 0; m_hc2 = 0; m_vf = 0;
    m_sc = 0; m_hc = 0; m_vco = 0; m_bpd = 0;
    m_phase = 0; m_stops = 0; m_q = {}; pdq = {};
    m_prev_w = 0; e_commit = 0; e_pd = 0;
  endtask

  task automatic model_apply();
    int w;
    w = 0;
    foreach (m_q[i]) w = (w << 1) | int'(m_q[i]);
    case (w & 7)
      0: begin m_rxg = (w >> 3) & 31; m_sel = (w >> 8) & 3;
               m_fm = (w >> 10) & 3; m_gc = (w >> 12) & 3; end
      1: begin m_tx = (w >> 3) & 15; m_gpo = (w >> 7) & 7; end
      2: begin m_osr = (w >> 3) & 1; m_lb = (w >> 4) & 3; m_ven = (w >> 6) & 1;
               m_hc2 = (w >> 7) & 1; m_vf = (w >> 8) & 1;
               m_sc = (w >> 9) & 7; m_hc = (w >> 12) & 7; end
      3: m_vco = (w >> 3) & 255;
      4: m_bpd = (w >> 3) & 255;
      default: ;
    endcase
    e_commit = ((w & 7) < 5);
  endtask

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) model_reset();
    else begin
      e_commit = 0;
      pdq.push_back(pd_in);
      e_pd = (pdq.size() >= 2) ? pdq[pdq.size()-2] : 1'b0;
      if (pdq.size() > 4) void'(pdq.pop_front());
      if (m_prev_w && !wclk) begin
        if (m_phase == 0) begin
          if (!sdin) begin m_phase = 1; m_q = {}; end
        end else if (m_phase == 1) begin
          m_q.push_back(sdin);
          if (m_q.size() == 15) begin m_phase = 2; m_stops = 0; end
        end else begin
          if (!sdin) begin m_phase = 1; m_q = {}; end
          else begin
            m_stops++;
            if (m_stops == 16) begin model_apply(); m_phase = 0; end
          end
        end
      end
      m_prev_w = wclk;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      if (commit) ncommit++;
      chk("R7 rx_gain", 32'(rx_gain), 32'(m_rxg));
      chk("R7 rx_in_sel", 32'(rx_in_sel), 32'(m_sel));
      chk("R7 rx_filt_mode", 32'(rx_filt_mode), 32'(m_fm));
      chk("R7 ext_gc", 32'(ext_gc), 32'(m_gc));
      chk("R8 R11 tx_gain", 32'(tx_gain), e_pd ? 32'd15 : 32'(m_tx));
      chk("R8 gpo", 32'(gpo), 32'(m_gpo));
      chk("R9 osr2", 32'(osr2), 32'(m_osr));
      chk("R9 loopback", 32'(loopback), 32'(m_lb));
      chk("R9 vcodac_en", 32'(vcodac_en), 32'(m_ven));
      chk("R9 hc2_en", 32'(hc2_en), 32'(m_hc2));
      chk("R9 vcxo_filt", 32'(vcxo_filt), 32'(m_vf));
      chk("R9 sc_tune", 32'(sc_tune), 32'(m_sc));
      chk("R9 hc_tune", 32'(hc_tune), 32'(m_hc));
      chk("R10 vcodac_val", 32'(vcodac_val), 32'(m_vco));
      chk("R10 blk_pd", 32'(blk_pd), 32'(m_bpd));
      chk("R11 pd_active", 32'(pd_active), 32'(e_pd));
      chk("R3 R12 commit", 32'(commit), 32'(e_commit));
    end
  end

  // One serial bit: word clock high for 4 cycles, low for 4; optional glitch while high
  task automatic send_bit(bit b, bit glitch = 0);
    @(negedge clk); sdin = b; wclk = 1'b1;
    @(negedge clk); if (glitch) sdin = ~b;
    @(negedge clk); sdin = b;
    repeat (2) @(negedge clk);
    wclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(int w, int nstops, bit glitch = 0);
    send_bit(1'b0, glitch);
    for (int i = 14; i >= 0; i--) send_bit(w[i], glitch);
    for (int i = 0; i < nstops; i++) send_bit(1'b1, glitch);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 rx_in_sel reset", 32'(rx_in_sel), 32'd3);
    chk("R6 tx_gain reset", 32'(tx_gain), 32'd0);
    chk("R6 vcodac_en reset", 32'(vcodac_en), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R7: receive settings
    send_word((17 << 3) | (1 << 8) | (2 << 10) | (3 << 12) | 0, 16);
    chk("R7 rx_gain value", 32'(rx_gain), 32'd17);
    chk("R2 R7 ext_gc value", 32'(ext_gc), 32'd3);
    // R8: transmit settings
    send_word((9 << 3) | (5 << 7) | 1, 16);
    chk("R8 tx_gain value", 32'(tx_gain), 32'd9);
    // R9: mode settings, transmit tuning -3, receive tuning +3
    send_word((1 << 3) | (2 << 4) | (1 << 6) | (1 << 8) | (5 << 9) | (3 << 12) | 2, 16);
    chk("R9 sc_tune value", 32'(sc_tune), 32'd5);
    chk("R9 hc_tune value", 32'(hc_tune), 32'd3);
    // R10
    send_word((8'hA5 << 3) | 3, 16);
    chk("R10 vcodac_val value", 32'(vcodac_val), 32'hA5);
    send_word((8'h3C << 3) | 4, 16);
    chk("R10 blk_pd value", 32'(blk_pd), 32'h3C);

    // R3: 15 idle bits are not enough, the 16th commits
    send_word((31 << 3) | (2 << 8) | 0, 15);
    chk("R3 no commit after 15 stops", 32'(rx_gain), 32'd17);
    send_bit(1'b1);
    chk("R3 commit on 16th stop", 32'(rx_gain), 32'd31);

    // R4: truncated frame discarded, low bit starts the next frame
    send_word((2 << 3) | 1, 10);
    chk("R4 truncated frame held", 32'(tx_gain), 32'd9);
    send_word((12 << 3) | 1, 16);
    chk("R4 restarted frame applied", 32'(tx_gain), 32'd12);

    // R5: reserved identifiers
    for (int id = 5; id < 8; id++) send_word((12'hFFF << 3) | id, 16);
    chk("R5 reserved rx_gain", 32'(rx_gain), 32'd31);
    chk("R5 reserved vcodac_val", 32'(vcodac_val), 32'hA5);

    // R1: glitches between word-clock falling edges ignored
    send_word((8'h5A << 3) | 3, 16, 1'b1);
    chk("R1 glitch immune", 32'(vcodac_val), 32'h5A);

    // R11: power-down
    pd_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 pd_active", 32'(pd_active), 32'd1);
    chk("R11 tx forced", 32'(tx_gain), 32'd15);
    send_word((4 << 3) | 1, 16);
    chk("R11 tx forced during write", 32'(tx_gain), 32'd15);
    pd_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 stored tx restored", 32'(tx_gain), 32'd4);

    // R12: one pulse per committed frame
    chk("R12 commit count", 32'(ncommit), 32'd9);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule